// File: doc/BRIEF.md
# Load/Store Effective-Address and Data-Extension Unit

This unit carries out the memory step of a 32-bit processor in which only loads and stores reach memory. For each request the core supplies an operation code, a base register index and value, an immediate-select bit with a 13-bit displacement field, the value of the register that field names when no immediate is used, store data and a destination register index. The unit forms the effective address, aligns and strobes the data lanes, and for loads returns the value zero- or sign-extended to 32 bits, ready to be written to the register file.

Every access spans two cycles. In the address cycle the request is sampled, the effective address is formed, the misalignment test is made, and everything is latched at the clock edge. In the following transfer cycle the memory port is driven. For a load, the extended result is also presented for write-back in that cycle, taken combinationally from the read data. A new request may be presented in a transfer cycle, so address and transfer steps overlap. Register 0 reads as zero, so a base index of 0 gives absolute addressing and a zero displacement gives register-indirect addressing.

Top module: `memx_unit`

## Requirements
- R1: The effective address is base plus displacement, modulo 2^32. When the base index is 0, the base counts as zero whatever the base value input carries.
- R2: With the immediate select at 1, the displacement is the 13-bit field sign-extended to 32 bits. With it at 0, the displacement is the supplied register value, or zero when the field's low 5 bits (the register index) are 0.
- R3: A request accepted at a clock edge is driven on the memory port in the cycle after that edge, for exactly that one cycle. In a cycle not preceded by an accepted request, mem_we, mem_re, wb_en and misalign are all low and mem_be is 0.
- R4: busy is high in every cycle in which req_valid presents an address-generation step.
- R5: Operation codes: 0 byte load sign-extended, 1 byte load zero-extended, 2 halfword load sign-extended, 3 halfword load zero-extended, 4 word load, 5 byte store, 6 halfword store, 7 word store. A load drives mem_re and wb_en, and puts the destination index on wb_idx.
- R6: Byte lanes are little-endian: lane k is mem_rdata/mem_wdata bits 8k+7..8k. A byte access uses lane addr[1:0], a halfword uses lanes 1..0 (addr[1]=0) or 3..2 (addr[1]=1), and a word uses all four. A load returns the selected bytes with bit 0 of the lowest lane at wb_data bit 0.
- R7: A store drives mem_we and the full effective address. It drives mem_be with only the accessed lanes set, and mem_wdata with the low byte (byte store) or low halfword (halfword store) of the store data copied onto every lane.
- R8: A halfword access with addr[0]=1, or a word access with addr[1:0]≠0, raises misalign in its transfer cycle. It holds mem_we, mem_re and wb_en low and mem_be at 0.
- R9: While reset is held, and in the first cycle after it, no strobe, write-back or misalign is driven.
- R10: Requests on consecutive cycles are each completed in their own transfer cycle, in order, and each keeps its own address, data and destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request presented this cycle |
| req_op | input | 3 | Operation code (see R5) |
| base_idx | input | 5 | Base register index (0 reads as zero) |
| base_val | input | 32 | Base register value |
| imm_sel | input | 1 | 1: immediate displacement, 0: register displacement |
| disp_field | input | 13 | Immediate field; low 5 bits are the register index when imm_sel=0 |
| idx_val | input | 32 | Value of the displacement register |
| store_val | input | 32 | Store data |
| dst_idx | input | 5 | Destination register for loads |
| busy | output | 1 | Address step in progress; core holds issue |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Byte-lane enables |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Memory read data, valid in the cycle mem_re is high |
| misalign | output | 1 | Misaligned access flag |
| wb_en | output | 1 | Register write-back enable |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 32 | Extended load result |

## Verification
busy is due in the cycle of the request itself. Memory strobes, lane enables, write data, the misalign flag and the load result are all due in the single cycle after the clock edge that sampled the request. The driver stamps each expected item with the number of the edge that will take the request, plus one. The monitor samples on the falling edge and compares an item only when the count of rising edges matches that stamp. In every other cycle it checks that the port is idle, so an early, late or doubled transfer shows up as a miscompare. The bench's memory returns read data as a function of address, so load results are predicted without any state.

// File: rtl/memx_pkg.sv
package memx_pkg;

  typedef enum logic [2:0] {
    OP_LDB  = 3'd0,
    OP_LDBU = 3'd1,
    OP_LDH  = 3'd2,
    OP_LDHU = 3'd3,
    OP_LDW  = 3'd4,
    OP_STB  = 3'd5,
    OP_STH  = 3'd6,
    OP_STW  = 3'd7
  } mop_e;

  // log2 of the access size in bytes
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } msize_e;

  function automatic logic op_is_load(mop_e op);
    return (op == OP_LDB) || (op == OP_LDBU) || (op == OP_LDH) ||
           (op == OP_LDHU) || (op == OP_LDW);
  endfunction

  function automatic logic op_zero_ext(mop_e op);
    return (op == OP_LDBU) || (op == OP_LDHU);
  endfunction

  function automatic msize_e op_size(mop_e op);
    case (op)
      OP_LDB, OP_LDBU, OP_STB: return SZ_BYTE;
      OP_LDH, OP_LDHU, OP_STH: return SZ_HALF;
      default:                 return SZ_WORD;
    endcase
  endfunction

endpackage

// File: rtl/memx_agen.sv
module memx_agen #(
  parameter int XLEN   = 32,
  parameter int DISP_W = 13,
  parameter int RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [XLEN-1:0]   base_val,
  input  logic              imm_sel,
  input  logic [DISP_W-1:0] disp_field,
  input  logic [XLEN-1:0]   idx_val,
  output logic [XLEN-1:0]   ea
);

  function automatic logic [XLEN-1:0] sext_disp(input logic [DISP_W-1:0] f);
    return {{(XLEN-DISP_W){f[DISP_W-1]}}, f};
  endfunction

  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] disp_eff;

  // register 0 is hardwired to zero, on both operand paths
  always_comb begin
    base_eff = (base_idx == '0) ? '0 : base_val;
    if (imm_sel)
      disp_eff = sext_disp(disp_field);
    else if (disp_field[RIDX_W-1:0] == '0)
      disp_eff = '0;
    else
      disp_eff = idx_val;
    ea = base_eff + disp_eff;
  end

endmodule

// File: rtl/memx_store_lane.sv
module memx_store_lane #(
  parameter  int XLEN  = 32,
  localparam int LANES = XLEN / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [1:0]       sz,
  input  logic [OFS_W-1:0] ofs,
  input  logic [XLEN-1:0]  sdata,
  output logic [XLEN-1:0]  wdata,
  output logic [LANES-1:0] lane_en
);

  logic [OFS_W-1:0] sz_mask;
  assign sz_mask = OFS_W'((1 << sz) - 1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFS_W-1:0] POS = OFS_W'(i);
    logic [XLEN-1:0] src_shift;
    // a lane belongs to the access when it lies in the same size-aligned group
    assign lane_en[i] = ((POS & ~sz_mask) == (ofs & ~sz_mask));
    // each lane carries the data byte of its position within the group
    assign src_shift = sdata >> {POS & sz_mask, 3'b000};
    assign wdata[8*i +: 8] = src_shift[7:0];
  end

endmodule

// File: rtl/memx_load_ext.sv
module memx_load_ext #(
  parameter  int XLEN  = 32,
  localparam int OFS_W = $clog2(XLEN / 8)
) (
  input  logic [1:0]       sz,
  input  logic             zext,
  input  logic [OFS_W-1:0] ofs,
  input  logic [XLEN-1:0]  rdata,
  output logic [XLEN-1:0]  result
);

  logic [OFS_W-1:0] sz_mask;
  logic [XLEN-1:0]  aligned;

  assign sz_mask = OFS_W'((1 << sz) - 1);
  assign aligned = rdata >> {ofs & ~sz_mask, 3'b000};

  always_comb begin
    case (sz)
      2'd0:    result = {{(XLEN-8){~zext & aligned[7]}}, aligned[7:0]};
      2'd1:    result = {{(XLEN-16){~zext & aligned[15]}}, aligned[15:0]};
      default: result = aligned;
    endcase
  end

endmodule

// File: rtl/memx_unit.sv
module memx_unit
  import memx_pkg::*;
#(
  parameter  int XLEN   = 32,
  parameter  int DISP_W = 13,
  parameter  int RIDX_W = 5,
  localparam int LANES  = XLEN / 8,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [XLEN-1:0]   base_val,
  input  logic              imm_sel,
  input  logic [DISP_W-1:0] disp_field,
  input  logic [XLEN-1:0]   idx_val,
  input  logic [XLEN-1:0]   store_val,
  input  logic [RIDX_W-1:0] dst_idx,
  output logic              busy,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  output logic [LANES-1:0]  mem_be,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              misalign,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data
);

  function automatic logic off_misaligned(input msize_e sz, input logic [OFS_W-1:0] ofs);
    return |(ofs & OFS_W'((1 << sz) - 1));
  endfunction

  // ---------------- address cycle ----------------
  mop_e            op_now;
  logic [XLEN-1:0] ea_now;
  logic            mis_now;

  assign op_now = mop_e'(req_op);

  memx_agen #(.XLEN(XLEN), .DISP_W(DISP_W), .RIDX_W(RIDX_W)) u_agen (
    .base_idx   (base_idx),
    .base_val   (base_val),
    .imm_sel    (imm_sel),
    .disp_field (disp_field),
    .idx_val    (idx_val),
    .ea         (ea_now)
  );

  assign mis_now = off_misaligned(op_size(op_now), ea_now[OFS_W-1:0]);

  // named phase events
  logic addr_phase;
  logic xfer_phase;
  assign addr_phase = req_valid;
  assign busy       = addr_phase;

  // ---------------- stage register ----------------
  logic              x_valid;
  mop_e              x_op;
  logic [XLEN-1:0]   x_ea;
  logic [XLEN-1:0]   x_sdata;
  logic [RIDX_W-1:0] x_dst;
  logic              x_mis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_valid <= 1'b0;
      x_op    <= OP_LDW;
      x_ea    <= '0;
      x_sdata <= '0;
      x_dst   <= '0;
      x_mis   <= 1'b0;
    end else begin
      x_valid <= addr_phase;
      if (addr_phase) begin
        x_op    <= op_now;
        x_ea    <= ea_now;
        x_sdata <= store_val;
        x_dst   <= dst_idx;
        x_mis   <= mis_now;
      end
    end
  end

  assign xfer_phase = x_valid;

  // ---------------- transfer cycle ----------------
  logic             xfer_ok;
  logic             x_load;
  msize_e           x_sz;
  logic [LANES-1:0] lane_en;
  logic [XLEN-1:0]  lane_data;
  logic [XLEN-1:0]  ld_result;

  assign x_load  = op_is_load(x_op);
  assign x_sz    = op_size(x_op);
  assign xfer_ok = xfer_phase & ~x_mis;

  memx_store_lane #(.XLEN(XLEN)) u_lane (
    .sz      (x_sz),
    .ofs     (x_ea[OFS_W-1:0]),
    .sdata   (x_sdata),
    .wdata   (lane_data),
    .lane_en (lane_en)
  );

  memx_load_ext #(.XLEN(XLEN)) u_ext (
    .sz     (x_sz),
    .zext   (op_zero_ext(x_op)),
    .ofs    (x_ea[OFS_W-1:0]),
    .rdata  (mem_rdata),
    .result (ld_result)
  );

  assign mem_addr  = x_ea;
  assign mem_wdata = lane_data;
  assign mem_be    = xfer_ok ? lane_en : '0;
  assign mem_we    = xfer_ok & ~x_load;
  assign mem_re    = xfer_ok & x_load;
  assign misalign  = xfer_phase & x_mis;
  assign wb_en     = mem_re;
  assign wb_idx    = x_dst;
  assign wb_data   = ld_result;

endmodule

// File: rtl/memx_unit_chk.sv
module memx_unit_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_phase,
  input logic             xfer_phase,
  input logic             busy,
  input logic             mem_we,
  input logic             mem_re,
  input logic [LANES-1:0] mem_be,
  input logic             misalign,
  input logic             wb_en
);

  AST_XFER_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> xfer_phase);  // R3

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_phase |=> (!mem_we && !mem_re && !wb_en && !misalign && mem_be == '0));  // R3

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_phase |-> ($countones({mem_we, mem_re, misalign}) == 1));  // R3

  AST_BUSY_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |-> busy);  // R4

  AST_WB_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (mem_re && !mem_we));  // R5

  AST_STORE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                $countones(mem_be) == 4));  // R7

  AST_MIS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_we && !mem_re && !wb_en && mem_be == '0));  // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!mem_we && !mem_re && !wb_en && !misalign));  // R9

endmodule

bind memx_unit memx_unit_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_phase (addr_phase),
  .xfer_phase (xfer_phase),
  .busy       (busy),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .mem_be     (mem_be),
  .misalign   (misalign),
  .wb_en      (wb_en)
);

// File: tb/memx_unit_bench.sv
`timescale 1ns/1ps
module memx_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [4:0]  base_idx;
  logic [31:0] base_val;
  logic        imm_sel;
  logic [12:0] disp_field;
  logic [31:0] idx_val;
  logic [31:0] store_val;
  logic [4:0]  dst_idx;
  logic        busy;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_we;
  logic        mem_re;
  logic [31:0] mem_rdata;
  logic        misalign;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  always #2 clk = ~clk;  // 250 MHz

  memx_unit u_memx_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .base_idx(base_idx), .base_val(base_val), .imm_sel(imm_sel),
    .disp_field(disp_field), .idx_val(idx_val), .store_val(store_val),
    .dst_idx(dst_idx), .busy(busy), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .misalign(misalign), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  // stateless memory: each word's bytes derive from its word address
  function automatic logic [31:0] pat(input logic [31:0] a);
    logic [7:0] k;
    k = a[9:2];
    return {k ^ 8'hC6, k + 8'h5B, ~k, k ^ 8'h81};
  endfunction
  assign mem_rdata = pat(mem_addr);

  typedef struct {
    int          due;
    logic        mis, we, re;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] wbd;
    logic [4:0]  wbi;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic issue(input logic [2:0] op, input logic [4:0] bi, input logic [31:0] bv,
                       input logic im, input logic [12:0] d, input logic [31:0] iv,
                       input logic [31:0] sd, input logic [4:0] dst, input string tag);
    exp_t        e;
    logic [31:0] base, disp, ea, w;
    logic [1:0]  off;
    logic [7:0]  b;
    logic [15:0] h;
    int          n;
    logic        ld;
    req_valid = 1'b1; req_op = op; base_idx = bi; base_val = bv; imm_sel = im;
    disp_field = d; idx_val = iv; store_val = sd; dst_idx = dst;
    base = (bi == 5'd0) ? 32'd0 : bv;
    if (im) disp = {{19{d[12]}}, d};
    else    disp = (d[4:0] == 5'd0) ? 32'd0 : iv;
    ea  = base + disp;
    off = ea[1:0];
    case (op)
      3'd0, 3'd1, 3'd5: n = 1;
      3'd2, 3'd3, 3'd6: n = 2;
      default:          n = 4;
    endcase
    ld = (op < 3'd5);
    e.tag  = tag;
    e.due  = cyc + 1;
    e.mis  = (n == 2 && off[0]) || (n == 4 && off != 2'd0);
    e.we   = !e.mis && !ld;
    e.re   = !e.mis && ld;
    e.addr = ea;
    case (n)
      1:       begin e.be = 4'b0001 << off; e.wdata = {4{sd[7:0]}}; end
      2:       begin e.be = off[1] ? 4'b1100 : 4'b0011; e.wdata = {2{sd[15:0]}}; end
      default: begin e.be = 4'b1111; e.wdata = sd; end
    endcase
    if (e.mis) e.be = 4'b0000;
    w = pat(ea);
    case (off)
      2'd0: b = w[7:0];
      2'd1: b = w[15:8];
      2'd2: b = w[23:16];
      default: b = w[31:24];
    endcase
    h = off[1] ? w[31:16] : w[15:0];
    case (op)
      3'd0:    e.wbd = {{24{b[7]}}, b};
      3'd1:    e.wbd = {24'd0, b};
      3'd2:    e.wbd = {{16{h[15]}}, h};
      3'd3:    e.wbd = {16'd0, h};
      default: e.wbd = w;
    endcase
    e.wbi = dst;
    q.push_back(e);
    #1;
    n_vec++;
    if (busy !== 1'b1) begin
      n_bad++;
      $display("FAIL R4 busy in address cycle (%s): got %b exp 1", tag, busy);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares the due item, otherwise expects a quiet port
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      bit   bad;
      e = q.pop_front();
      bad = 0;
      if (misalign !== e.mis || mem_we !== e.we || mem_re !== e.re ||
          wb_en !== e.re || mem_be !== e.be) bad = 1;
      if ((e.we || e.re) && mem_addr !== e.addr) bad = 1;
      if (e.we && ((mem_wdata & {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}}) !==
                   (e.wdata & {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}}))) bad = 1;
      if (e.re && (wb_data !== e.wbd || wb_idx !== e.wbi)) bad = 1;
      n_vec++;
      if (bad) begin
        n_bad++;
        $display("FAIL %s: got mis=%b we=%b re=%b wb=%b be=%h addr=%h wd=%h wbd=%h wbi=%0d exp mis=%b we=%b re=%b be=%h addr=%h wd=%h wbd=%h wbi=%0d",
                 e.tag, misalign, mem_we, mem_re, wb_en, mem_be, mem_addr, mem_wdata, wb_data, wb_idx,
                 e.mis, e.we, e.re, e.be, e.addr, e.wdata, e.wbd, e.wbi);
      end
    end else begin
      n_vec++;
      if (mem_we !== 1'b0 || mem_re !== 1'b0 || wb_en !== 1'b0 ||
          misalign !== 1'b0 || mem_be !== 4'b0000) begin
        n_bad++;
        $display("FAIL %s quiet cycle: got we=%b re=%b wb=%b mis=%b be=%h exp all 0",
                 rst_n ? "R3" : "R9", mem_we, mem_re, wb_en, misalign, mem_be);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; base_idx = 5'd0; base_val = 32'd0;
    imm_sel = 1'b0; disp_field = 13'd0; idx_val = 32'd0; store_val = 32'd0; dst_idx = 5'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: absolute (base index 0, stale base value ignored), word load
    issue(3'd4, 5'd0, 32'hDEAD_0000, 1'b1, 13'h0100, 32'h0, 32'h0, 5'd7, "R1 absolute word load");
    idle(1);
    // R1 R2: register indirect, zero immediate
    issue(3'd4, 5'd3, 32'h0000_0300, 1'b1, 13'h0000, 32'h0, 32'h0, 5'd8, "R2 register-indirect load");
    idle(1);
    // R2: register displacement
    issue(3'd4, 5'd4, 32'h0000_0200, 1'b0, 13'h0009, 32'h0000_0040, 32'h0, 5'd9, "R2 register displacement");
    idle(1);
    // R2: displacement register index 0 ignores idx_val
    issue(3'd4, 5'd4, 32'h0000_0180, 1'b0, 13'h1FE0, 32'h0000_7770, 32'h0, 5'd10, "R2 zero displacement register");
    idle(1);
    // R2: negative immediate
    issue(3'd4, 5'd5, 32'h0000_0104, 1'b1, 13'h1FF8, 32'h0, 32'h0, 5'd11, "R2 negative immediate");
    idle(1);
    // R1: wrap around 2^32
    issue(3'd4, 5'd6, 32'hFFFF_FFF0, 1'b1, 13'h0020, 32'h0, 32'h0, 5'd12, "R1 address wrap");
    idle(1);

    // R5 R6: byte loads, both extensions, every lane, two data sign patterns
    for (int k = 0; k < 4; k++) begin
      issue(3'd0, 5'd1, 32'h0000_0040, 1'b1, 13'(k), 32'h0, 32'h0, 5'd13, "R5 byte load signed");
      issue(3'd1, 5'd1, 32'h0000_0040, 1'b1, 13'(k), 32'h0, 32'h0, 5'd14, "R5 byte load unsigned");
      issue(3'd0, 5'd1, 32'h0000_0300, 1'b1, 13'(k), 32'h0, 32'h0, 5'd15, "R6 byte lane signed");
      idle(1);
    end
    // R5 R6: halfword loads in both halves
    for (int k = 0; k < 4; k += 2) begin
      issue(3'd2, 5'd2, 32'h0000_0100, 1'b1, 13'(k), 32'h0, 32'h0, 5'd16, "R5 half load signed");
      issue(3'd3, 5'd2, 32'h0000_0100, 1'b1, 13'(k), 32'h0, 32'h0, 5'd17, "R5 half load unsigned");
      issue(3'd2, 5'd2, 32'h0000_0300, 1'b1, 13'(k), 32'h0, 32'h0, 5'd18, "R6 half lane signed");
      idle(1);
    end

    // R7: stores on every legal lane
    for (int k = 0; k < 4; k++) begin
      issue(3'd5, 5'd2, 32'h0000_0800, 1'b1, 13'(k), 32'h0, 32'hA1B2_C3D4, 5'd0, "R7 byte store");
      idle(1);
    end
    issue(3'd6, 5'd2, 32'h0000_0800, 1'b1, 13'd0, 32'h0, 32'h1357_9BDF, 5'd0, "R7 half store low");
    issue(3'd6, 5'd2, 32'h0000_0800, 1'b1, 13'd2, 32'h0, 32'h1357_9BDF, 5'd0, "R7 half store high");
    issue(3'd7, 5'd2, 32'h0000_0800, 1'b1, 13'd4, 32'h0, 32'h0F1E_2D3C, 5'd0, "R7 word store");
    idle(2);

    // R8: misaligned halfword and word accesses
    issue(3'd2, 5'd1, 32'h0000_0400, 1'b1, 13'd1, 32'h0, 32'h0, 5'd20, "R8 half load odd");
    idle(1);
    issue(3'd4, 5'd1, 32'h0000_0400, 1'b1, 13'd2, 32'h0, 32'h0, 5'd21, "R8 word load offset 2");
    idle(1);
    issue(3'd7, 5'd1, 32'h0000_0400, 1'b1, 13'd3, 32'h0, 32'h5555_AAAA, 5'd0, "R8 word store offset 3");
    issue(3'd6, 5'd1, 32'h0000_0400, 1'b1, 13'd3, 32'h0, 32'h5555_AAAA, 5'd0, "R8 half store odd");
    idle(1);

    // R10: back-to-back mixed stream, including a misaligned one mid-stream
    issue(3'd4, 5'd9, 32'h0000_0500, 1'b1, 13'd8, 32'h0, 32'h0, 5'd22, "R10 stream word load");
    issue(3'd5, 5'd9, 32'h0000_0500, 1'b1, 13'd1, 32'h0, 32'h0000_00E7, 5'd0, "R10 stream byte store");
    issue(3'd3, 5'd9, 32'h0000_0500, 1'b1, 13'd1, 32'h0, 32'h0, 5'd23, "R10 stream misaligned half");
    issue(3'd0, 5'd9, 32'h0000_0500, 1'b1, 13'd3, 32'h0, 32'h0, 5'd24, "R10 stream byte load");
    issue(3'd7, 5'd0, 32'h0, 1'b1, 13'h0FFC, 32'h0, 32'hCAFE_F00D, 5'd0, "R10 stream word store");
    idle(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule